// File: doc/BRIEF.md
# Page Bit-Error Correction Applier

This block sits behind a BCH decoder in a flash page controller. A page of 512 data bytes and 16 spare bytes lies in the block's own byte store, which a host port loads and reads back. After the decoder has run, the controller pulses `start` with the decoder's results: the seven syndrome bytes, up to four reported bit-error positions with a count, a syndrome-error flag and an uncorrectable flag. The block then decides whether a correction is due and applies each flip to the stored page.

Two bypasses come before any flip. A syndrome equal to the fixed erased-page signature means the page was never written. A last spare byte that is nonzero and has more than four bits set means a blank page that has picked up bit errors. Neither case changes the page. A page the decoder marks uncorrectable is left alone and reported as a failure. Otherwise each reported position is changed from reversed-bit order within its byte, checked against the 520-byte protected region, and flipped in the data bytes or the spare bytes. One flip is applied per cycle.

Top module: `ecc_flip_applier`

## Requirements
- R1: When `syn_err_flag` is low at `start`, no byte changes and the job ends with `corr_count` 0, `blank_page` 0 and `fail` 0.
- R2: When the syndrome equals the erased-page signature, no byte changes, `blank_page` is 1 and `corr_count` is 0. Syndrome byte k is `syndrome[8k+7:8k]`. Bytes 0 to 6 of the signature are CF 72 FC 1B A9 C7 B9. This check takes priority over R3 and R4.
- R3: When spare byte 15 is nonzero and has more than four bits set, no byte changes and `blank_page` is 1. A value with four or fewer bits set lets correction go ahead. This check takes priority over R4.
- R4: When `uncorrectable` is high, no byte changes, `fail` is 1, `blank_page` is 0 and `corr_count` is 0.
- R5: A reported position p selects linear byte p>>3 and bit 7-(p mod 8) of that byte, where bit 0 is the LSB. Slot k of `err_pos` is bits [13k+12:13k], and slots are applied in slot order.
- R6: A linear byte below 512 flips a bit in data byte (p>>3).
- R7: A linear byte from 512 to 519 flips a bit in spare byte (p>>3)-512.
- R8: A position whose linear byte is 520 or above changes nothing and is not counted.
- R9: At most four slots are applied. An `err_cnt` above 4 is treated as 4.
- R10: `corr_count` equals the number of flips actually applied. It holds, together with `blank_page` and `fail`, until the next accepted `start`.
- R11: `busy` is high from the cycle after an accepted `start` through the `done` cycle. `done` is a one-cycle pulse. A `start` while busy is ignored, and the job's inputs are captured at the accepted `start`.
- R12: A host write while `busy` is high is ignored, including one aimed at the byte being flipped.
- R13: After reset, every stored byte and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a correction job (accepted when idle) |
| syn_err_flag | input | 1 | Decoder reports a nonzero syndrome |
| syndrome | input | 56 | Seven syndrome bytes, byte 0 in the low bits |
| err_pos | input | 52 | Four 13-bit reported bit positions |
| err_cnt | input | 3 | Number of valid position slots |
| uncorrectable | input | 1 | Decoder could not correct the page |
| host_we | input | 1 | Host byte write strobe |
| host_spare | input | 1 | Host access selects spare bytes (1) or data bytes (0) |
| host_addr | input | 9 | Host byte address; the low 4 bits index the spare bytes |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Stored byte at the host address |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| corr_count | output | 3 | Flips applied in the last job |
| blank_page | output | 1 | Last job was bypassed as a blank page |
| fail | output | 1 | Last job was uncorrectable |

## Verification
A bit flip and a host write can target the same stored byte in the same cycle. The bench provokes this by holding a host write to byte 40 at 0x55 for the whole length of a job whose four flips all land in byte 40. The byte must read back as its old value with only the four flipped bits changed. During the same job a second `start` with different positions is pulsed. The count must still reflect the first job's positions, which shows that the captured inputs were not overwritten.

// File: rtl/ecc_flip_pkg.sv
package ecc_flip_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_FLIP,
        ST_DONE
    } fsm_e;

    // Syndrome of an erased page, byte 0 in the low bits.
    localparam logic [55:0] ERASED_SIG = 56'hB9C7A91BFC72CF;

endpackage

// File: rtl/ecc_pos_remap.sv
module ecc_pos_remap #(
    parameter int POS_W      = 13,
    parameter int DATA_BYTES = 512,
    parameter int PROT_BYTES = 520,
    parameter int AW         = 9
) (
    input  logic [POS_W-1:0] pos,
    output logic             to_spare,
    output logic             ignore,
    output logic [AW-1:0]    byte_idx,
    output logic [7:0]       bit_mask
);
    localparam logic [POS_W-1:0] DATA_LIM = POS_W'(DATA_BYTES * 8);
    localparam logic [POS_W-1:0] PROT_LIM = POS_W'(PROT_BYTES * 8);

    logic [POS_W-1:0] fixed;
    logic [POS_W-1:0] off;

    always_comb begin
        // bit index within a byte is reported mirrored: p -> 7 - p
        fixed    = {pos[POS_W-1:3], ~pos[2:0]};
        to_spare = (fixed >= DATA_LIM);
        ignore   = (fixed >= PROT_LIM);
        off      = to_spare ? (fixed - DATA_LIM) : fixed;
        byte_idx = AW'(off >> 3);
        bit_mask = 8'(1) << off[2:0];
    end
endmodule

// File: rtl/ecc_page_store.sv
module ecc_page_store #(
    parameter int DATA_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int AW          = 9,
    parameter int SW          = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic          host_spare,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic          flip_en,
    input  logic          flip_spare,
    input  logic [AW-1:0] flip_byte,
    input  logic [7:0]    flip_mask,
    output logic [7:0]    spare_last
);
    logic [7:0] data_q  [DATA_BYTES];
    logic [7:0] spare_q [SPARE_BYTES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DATA_BYTES; i++)  data_q[i]  <= '0;
            for (int i = 0; i < SPARE_BYTES; i++) spare_q[i] <= '0;
        end else if (flip_en) begin
            if (flip_spare) spare_q[SW'(flip_byte)] <= spare_q[SW'(flip_byte)] ^ flip_mask;
            else            data_q[flip_byte]       <= data_q[flip_byte] ^ flip_mask;
        end else if (host_we) begin
            if (host_spare) spare_q[SW'(host_addr)] <= host_wdata;
            else            data_q[host_addr]       <= host_wdata;
        end
    end

    assign host_rdata = host_spare ? spare_q[SW'(host_addr)] : data_q[host_addr];
    assign spare_last = spare_q[SPARE_BYTES-1];
endmodule

// File: rtl/ecc_flip_applier.sv
module ecc_flip_applier
    import ecc_flip_pkg::*;
#(
    parameter int DATA_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int PROT_BYTES  = 520,
    parameter int MAX_ERR     = 4,
    parameter int POS_W       = 13,
    parameter int BLANK_LIMIT = 4,
    localparam int AW         = $clog2(DATA_BYTES),
    localparam int CNT_W      = $clog2(MAX_ERR + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     syn_err_flag,
    input  logic [55:0]              syndrome,
    input  logic [MAX_ERR*POS_W-1:0] err_pos,
    input  logic [CNT_W-1:0]         err_cnt,
    input  logic                     uncorrectable,
    input  logic                     host_we,
    input  logic                     host_spare,
    input  logic [AW-1:0]            host_addr,
    input  logic [7:0]               host_wdata,
    output logic [7:0]               host_rdata,
    output logic                     busy,
    output logic                     done,
    output logic [CNT_W-1:0]         corr_count,
    output logic                     blank_page,
    output logic                     fail
);
    localparam int SW = $clog2(SPARE_BYTES);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_ERR);

    typedef struct packed {
        fsm_e                     st;
        logic [CNT_W-1:0]         idx;
        logic [CNT_W-1:0]         num;
        logic [CNT_W-1:0]         applied;
        logic [MAX_ERR*POS_W-1:0] pos;
        logic [55:0]              syn;
        logic                     en;
        logic                     unc;
        logic                     blank;
        logic                     fail;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [POS_W-1:0] pos_slot [MAX_ERR];
    logic [POS_W-1:0] cur_pos;
    logic             rm_spare, rm_ignore;
    logic [AW-1:0]    rm_byte;
    logic [7:0]       rm_mask;
    logic [7:0]       spare_last;
    logic             spare_blank;
    logic             flip_en;

    for (genvar g = 0; g < MAX_ERR; g++) begin : g_slot
        assign pos_slot[g] = c_q.pos[g*POS_W +: POS_W];
    end

    assign cur_pos = pos_slot[c_q.idx];

    ecc_pos_remap #(
        .POS_W     (POS_W),
        .DATA_BYTES(DATA_BYTES),
        .PROT_BYTES(PROT_BYTES),
        .AW        (AW)
    ) u_remap (
        .pos     (cur_pos),
        .to_spare(rm_spare),
        .ignore  (rm_ignore),
        .byte_idx(rm_byte),
        .bit_mask(rm_mask)
    );

    assign spare_blank = (spare_last != 8'h00) && ($countones(spare_last) > BLANK_LIMIT);
    assign flip_en     = (c_q.st == ST_FLIP) && !rm_ignore;

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st      = ST_EVAL;
                    c_d.pos     = err_pos;
                    c_d.syn     = syndrome;
                    c_d.en      = syn_err_flag;
                    c_d.unc     = uncorrectable;
                    c_d.num     = (err_cnt > MAX_CNT) ? MAX_CNT : err_cnt;
                    c_d.idx     = '0;
                    c_d.applied = '0;
                    c_d.blank   = 1'b0;
                    c_d.fail    = 1'b0;
                end
            end
            ST_EVAL: begin
                c_d.st = ST_DONE;
                if (!c_q.en) begin
                    c_d.st = ST_DONE;
                end else if (c_q.syn == ERASED_SIG) begin
                    c_d.blank = 1'b1;
                end else if (spare_blank) begin
                    c_d.blank = 1'b1;
                end else if (c_q.unc) begin
                    c_d.fail = 1'b1;
                end else if (c_q.num != '0) begin
                    c_d.st = ST_FLIP;
                end
            end
            ST_FLIP: begin
                if (!rm_ignore) c_d.applied = c_q.applied + 1'b1;
                if (c_q.idx == c_q.num - 1'b1) c_d.st  = ST_DONE;
                else                           c_d.idx = c_q.idx + 1'b1;
            end
            ST_DONE: c_d.st = ST_IDLE;
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    ecc_page_store #(
        .DATA_BYTES (DATA_BYTES),
        .SPARE_BYTES(SPARE_BYTES),
        .AW         (AW),
        .SW         (SW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we && !busy),
        .host_spare(host_spare),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .flip_en   (flip_en),
        .flip_spare(rm_spare),
        .flip_byte (rm_byte),
        .flip_mask (rm_mask),
        .spare_last(spare_last)
    );

    assign busy       = (c_q.st != ST_IDLE);
    assign done       = (c_q.st == ST_DONE);
    assign corr_count = c_q.applied;
    assign blank_page = c_q.blank;
    assign fail       = c_q.fail;
endmodule

// File: rtl/ecc_flip_checks.sv
module ecc_flip_checks #(
    parameter int CNT_W   = 3,
    parameter int MAX_ERR = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] corr_count,
    input logic             blank_page,
    input logic             fail
);
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_busy_ends_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    a_r4_fail_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (corr_count == '0 && !blank_page));

    a_r2_blank_no_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (done && blank_page) |-> (corr_count == '0));

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (corr_count <= CNT_W'(MAX_ERR)));

    a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(corr_count) && $stable(blank_page) && $stable(fail)));
endmodule

bind ecc_flip_applier ecc_flip_checks #(
    .CNT_W  (CNT_W),
    .MAX_ERR(MAX_ERR)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .corr_count(corr_count),
    .blank_page(blank_page),
    .fail      (fail)
);

// File: tb/ecc_flip_applier_bench.sv
`timescale 1ns/1ps
module ecc_flip_applier_bench;
    localparam int DB = 512;
    localparam int SB = 16;
    localparam logic [55:0] SIG   = 56'hB9C7A91BFC72CF;
    localparam logic [55:0] OTHER = 56'h0123456789ABCD;

    logic        clk = 1'b0;
    logic        rst_n, start, syn_err_flag, uncorrectable;
    logic [55:0] syndrome;
    logic [51:0] err_pos;
    logic [2:0]  err_cnt;
    logic        host_we, host_spare;
    logic [8:0]  host_addr;
    logic [7:0]  host_wdata, host_rdata;
    logic        busy, done, blank_page, fail;
    logic [2:0]  corr_count;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    logic [7:0] m_data  [DB];
    logic [7:0] m_spare [SB];

    always #4 clk = ~clk;

    ecc_flip_applier u_ecc_flip_applier (
        .clk(clk), .rst_n(rst_n), .start(start), .syn_err_flag(syn_err_flag),
        .syndrome(syndrome), .err_pos(err_pos), .err_cnt(err_cnt),
        .uncorrectable(uncorrectable), .host_we(host_we), .host_spare(host_spare),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .done(done), .corr_count(corr_count),
        .blank_page(blank_page), .fail(fail)
    );

    typedef struct packed {
        logic        en;
        logic        sig;
        logic        unc;
        logic [7:0]  sp15;
        logic [2:0]  cnt;
        logic [12:0] p0;
        logic [12:0] p1;
        logic [12:0] p2;
        logic [12:0] p3;
        logic [2:0]  xc;
        logic        xb;
        logic        xf;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 8'h00, 3'd2, 13'd10,   13'd20,   13'd0,    13'd0,    3'd0, 1'b0, 1'b0, 4'd1},  // R1 disabled
        '{1'b1, 1'b1, 1'b0, 8'h00, 3'd1, 13'd5,    13'd0,    13'd0,    13'd0,    3'd0, 1'b1, 1'b0, 4'd2},  // R2 erased sig
        '{1'b1, 1'b0, 1'b0, 8'h1F, 3'd1, 13'd5,    13'd0,    13'd0,    13'd0,    3'd0, 1'b1, 1'b0, 4'd3},  // R3 five bits set
        '{1'b1, 1'b0, 1'b0, 8'h0F, 3'd1, 13'd0,    13'd0,    13'd0,    13'd0,    3'd1, 1'b0, 1'b0, 4'd5},  // R5 R3 four bits ok
        '{1'b1, 1'b0, 1'b1, 8'h00, 3'd2, 13'd30,   13'd40,   13'd0,    13'd0,    3'd0, 1'b0, 1'b1, 4'd4},  // R4 uncorrectable
        '{1'b1, 1'b0, 1'b0, 8'h00, 3'd4, 13'd4095, 13'd4096, 13'd4159, 13'd4160, 3'd3, 1'b0, 1'b0, 4'd7},  // R7 R6 R8 edges
        '{1'b1, 1'b0, 1'b0, 8'h00, 3'd7, 13'd8,    13'd9,    13'd10,   13'd11,   3'd4, 1'b0, 1'b0, 4'd9},  // R9 clamp
        '{1'b1, 1'b0, 1'b0, 8'h00, 3'd0, 13'd8,    13'd0,    13'd0,    13'd0,    3'd0, 1'b0, 1'b0, 4'd10}, // R10 none
        '{1'b1, 1'b0, 1'b0, 8'h00, 3'd2, 13'd100,  13'd100,  13'd0,    13'd0,    3'd2, 1'b0, 1'b0, 4'd10}, // R10 same bit twice
        '{1'b1, 1'b0, 1'b0, 8'h00, 3'd3, 13'd8191, 13'd1000, 13'd4200, 13'd0,    3'd1, 1'b0, 1'b0, 4'd8},  // R8 ignored slots
        '{1'b1, 1'b1, 1'b1, 8'h00, 3'd1, 13'd5,    13'd0,    13'd0,    13'd0,    3'd0, 1'b1, 1'b0, 4'd2}   // R2 over R4
    };

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11"; 12: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp_v);
        end
    endtask

    task automatic host_write(input bit sp, input int a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_spare = sp; host_addr = 9'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input bit sp, input int a, output logic [7:0] d);
        @(negedge clk);
        host_spare = sp; host_addr = 9'(a);
        #1 d = host_rdata;
    endtask

    task automatic compare_buffers(input string tag);
        logic [7:0] v;
        int bad = 0;
        int where = 0;
        logic [7:0] act_b = 8'h00;
        logic [7:0] exp_b = 8'h00;
        for (int i = 0; i < DB + SB; i++) begin
            if (i < DB) host_read(1'b0, i, v);
            else        host_read(1'b1, i - DB, v);
            if (v !== ((i < DB) ? m_data[i] : m_spare[i - DB])) begin
                if (bad == 0) begin
                    where = i; act_b = v;
                    exp_b = (i < DB) ? m_data[i] : m_spare[i - DB];
                end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s buffer byte %0d actual %0h expected %0h", tag, where, act_b, exp_b);
        end
    endtask

    // Expected flip, from R5..R8: byte p>>3, bit 7-(p mod 8)
    task automatic model_flip(input int p);
        int b;
        int bi;
        b  = p >> 3;
        bi = 7 - (p & 7);
        if (b < DB)           m_data[b]       = m_data[b] ^ (8'(1) << bi);
        else if (b < DB + 8)  m_spare[b - DB] = m_spare[b - DB] ^ (8'(1) << bi);
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 40; k++) begin
            #1;
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !finished) begin
                checks++; errors++;
                $display("FAIL R11 watchdog actual hung expected done");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        vec_t t;
        string tg;
        bit ok;
        logic [7:0] rb;
        int n;
        logic [12:0] ps [4];

        rst_n = 1'b0; start = 1'b0; syn_err_flag = 1'b0; uncorrectable = 1'b0;
        syndrome = OTHER; err_pos = '0; err_cnt = '0;
        host_we = 1'b0; host_spare = 1'b0; host_addr = '0; host_wdata = '0;
        for (int i = 0; i < DB; i++) m_data[i] = 8'h00;
        for (int i = 0; i < SB; i++) m_spare[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R13 reset state
        check("R13", busy, 0);
        check("R13", done, 0);
        check("R13", corr_count, 0);
        check("R13", blank_page, 0);
        check("R13", fail, 0);
        host_read(1'b0, 3, rb);  check("R13", rb, 8'h00);
        host_read(1'b1, 15, rb); check("R13", rb, 8'h00);

        for (int v = 0; v < NV; v++) begin
            t  = VECS[v];
            tg = tag_name(int'(t.tag));
            host_write(1'b1, 15, t.sp15);
            m_spare[15] = t.sp15;
            @(negedge clk);
            syn_err_flag  = t.en;
            syndrome      = t.sig ? SIG : OTHER;
            uncorrectable = t.unc;
            err_cnt       = t.cnt;
            err_pos       = {t.p3, t.p2, t.p1, t.p0};
            start         = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done(ok);
            check(tg, ok, 1);
            check(tg, corr_count, t.xc);
            check(tg, blank_page, t.xb);
            check(tg, fail, t.xf);
            if (t.en && !t.sig && !(t.sp15 != 0 && $countones(t.sp15) > 4) && !t.unc) begin
                ps[0] = t.p0; ps[1] = t.p1; ps[2] = t.p2; ps[3] = t.p3;
                n = (t.cnt > 3'd4) ? 4 : int'(t.cnt);
                for (int k = 0; k < n; k++) model_flip(int'(ps[k]));
            end
            compare_buffers(tg);
        end

        // R12 host write on the flipped byte during the job; R11 second start ignored
        @(negedge clk);
        syn_err_flag = 1'b1; syndrome = OTHER; uncorrectable = 1'b0;
        err_cnt = 3'd4; err_pos = {13'd323, 13'd322, 13'd321, 13'd320};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        host_we = 1'b1; host_spare = 1'b0; host_addr = 9'd40; host_wdata = 8'h55;
        @(negedge clk);
        start = 1'b1; err_cnt = 3'd1; err_pos = {4{13'd8000}};
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        host_we = 1'b0;
        check("R11", ok, 1);
        check("R11", corr_count, 3'd4);
        for (int k = 320; k < 324; k++) model_flip(k);
        @(negedge clk);
        #1;
        check("R11", done, 0);
        check("R11", busy, 0);
        host_read(1'b0, 40, rb);
        check("R12", rb, m_data[40]);
        compare_buffers("R12");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule